// File: doc/BRIEF.md
# 4x4 Sum of Absolute Differences Unit

This block scores how closely a 4x4 block of current-frame pixels matches a 4x4 block of reference-frame pixels. It takes sixteen 8-bit pixel pairs at once and forms all sixteen absolute differences in parallel. It then adds the differences into a single sum of absolute differences (SAD). The lower score marks the better candidate in a motion search.

The sixteen differences pass through several levels of 3:2 carry-save compressors. Each level cuts three operands down to two without propagating any carry. When only two vectors remain, one carry-propagate adder turns them into the 12-bit result.

A full 16x16 macroblock is covered by placing sixteen of these units side by side. The search control and pixel fetch logic sit outside the block. An input sample is captured on the clock edge where `in_valid` is high. The result and `out_valid` appear one cycle later. A parameter can add an output register, which makes the latency two cycles.

Top module: `sad4x4_csa`

## Requirements
- R1: While `rst_n` is low, and after its release until the first captured sample, `out_valid` is 0 and `sad_out` is 0.
- R2: `out_valid` is 1 in exactly the cycle after a clock edge that sampled `in_valid` high, and 0 otherwise (default latency of one cycle).
- R3: `sad_out` equals the sum over i = 0..15 of |cur_i − ref_i|. Pixel i of `cur_pix` and of `ref_pix` occupies bits [8i+7:8i].
- R4: Each difference is an unsigned magnitude, so exchanging `cur_pix` and `ref_pix` leaves `sad_out` unchanged.
- R5: All pixels 255 against all pixels 0, in either direction, gives 4080 with no wrap, and `sad_out` never exceeds 4080.
- R6: Identical current and reference blocks give `sad_out` = 0.
- R7: While `in_valid` is low, the pixel inputs are ignored and `sad_out` holds the last result.
- R8: With `in_valid` high on consecutive cycles, a new correct result appears on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Pixel inputs are valid and are captured this cycle |
| cur_pix | input | 128 | Sixteen current-block pixels, pixel i at [8i+7:8i] |
| ref_pix | input | 128 | Sixteen reference-block pixels, same layout |
| out_valid | output | 1 | `sad_out` carries a fresh result |
| sad_out | output | 12 | Sum of absolute differences |

## Verification
The bound checker evaluates properties on every cycle:
- the valid flag follows `in_valid` by the configured latency;
- the result stays stable when no sample was taken;
- the result never rises above the largest possible sum;
- identical blocks always produce zero.

The exact arithmetic can only be shown by the bench's scenarios. These compare the result against a software sum over random pixel blocks, the all-zero and all-255 extremes, swapped operands, and back-to-back samples.

// File: rtl/sad_pkg.sv
package sad_pkg;
   // Operand count after a given number of 3:2 reduction levels
   function automatic int csa_count(input int n, input int lvl);
      int c;
      c = n;
      for (int i = 0; i < lvl; i++) begin
         if (c > 2) c = 2 * (c / 3) + (c % 3);
      end
      return c;
   endfunction

   // Number of levels needed to reach two operands
   function automatic int csa_levels(input int n);
      int c;
      int lv;
      c = n;
      lv = 0;
      while (c > 2) begin
         c = 2 * (c / 3) + (c % 3);
         lv++;
      end
      return lv;
   endfunction

   function automatic int max_sum(input int n, input int pw);
      return n * ((1 << pw) - 1);
   endfunction
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
   parameter int PIX_W = 8,
   parameter int OUT_W = 12
) (
   input  logic [PIX_W-1:0] a_i,
   input  logic [PIX_W-1:0] b_i,
   output logic [OUT_W-1:0] mag_o
);
   logic [PIX_W:0]   delta;
   logic             borrow;
   logic [PIX_W-1:0] mag;

   always_comb begin
      delta  = {1'b0, a_i} - {1'b0, b_i};
      borrow = delta[PIX_W];
      mag    = borrow ? (~delta[PIX_W-1:0] + 1'b1) : delta[PIX_W-1:0];
      mag_o  = {{(OUT_W-PIX_W){1'b0}}, mag};
   end
endmodule

// File: rtl/sad_csa3.sv
module sad_csa3 #(
   parameter int W = 12
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);
   logic [W-1:0] maj;

   always_comb begin
      sum_o = x_i ^ y_i ^ z_i;
      maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
      cry_o = {maj[W-2:0], 1'b0};
   end
endmodule

// File: rtl/sad_csa_tree.sv
module sad_csa_tree
   import sad_pkg::*;
#(
   parameter int N = 16,
   parameter int W = 12
) (
   input  logic [W-1:0] ops_i [N],
   output logic [W-1:0] vec_a_o,
   output logic [W-1:0] vec_b_o
);
   localparam int LV = csa_levels(N);

   if (N < 2) begin : g_bad_n
      $error("sad_csa_tree: N must be at least 2");
   end

   for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int C  = csa_count(N, l);
      localparam int G  = C / 3;
      localparam int R  = C % 3;
      localparam int NC = 2 * G + R;
      logic [W-1:0] v [C];
      logic [W-1:0] o [NC];

      for (genvar i = 0; i < C; i++) begin : g_in
         if (l == 0) begin : g_first
            assign v[i] = ops_i[i];
         end else begin : g_next
            assign v[i] = g_lvl[l-1].o[i];
         end
      end

      for (genvar g = 0; g < G; g++) begin : g_grp
         sad_csa3 #(.W(W)) u_csa (
            .x_i  (v[3*g]),
            .y_i  (v[3*g+1]),
            .z_i  (v[3*g+2]),
            .sum_o(o[2*g]),
            .cry_o(o[2*g+1])
         );
      end

      for (genvar r = 0; r < R; r++) begin : g_pass
         assign o[2*G+r] = v[3*G+r];
      end
   end

   if (LV == 0) begin : g_direct
      assign vec_a_o = ops_i[0];
      assign vec_b_o = ops_i[1];
   end else begin : g_tail
      assign vec_a_o = g_lvl[LV-1].o[0];
      assign vec_b_o = g_lvl[LV-1].o[1];
   end
endmodule

// File: rtl/sad_cpa.sv
module sad_cpa #(
   parameter int W = 12
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o
);
   assign sum_o = a_i + b_i;
endmodule

// File: rtl/sad4x4_csa.sv
module sad4x4_csa
   import sad_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int NUM_PIX = 16,
   parameter int SAD_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [NUM_PIX*PIX_W-1:0] cur_pix,
   input  logic [NUM_PIX*PIX_W-1:0] ref_pix,
   output logic                     out_valid,
   output logic [SAD_W-1:0]         sad_out
);
   localparam int FLAT_W  = NUM_PIX * PIX_W;
   localparam int SUM_MAX = max_sum(NUM_PIX, PIX_W);

   if (PIX_W < 2) begin : g_bad_pix
      $error("sad4x4_csa: PIX_W must be at least 2");
   end
   if (NUM_PIX < 2) begin : g_bad_num
      $error("sad4x4_csa: NUM_PIX must be at least 2");
   end
   if (SAD_W < PIX_W + $clog2(NUM_PIX) || SUM_MAX >= (1 << SAD_W)) begin : g_bad_sad
      $error("sad4x4_csa: SAD_W too narrow for the largest sum");
   end

   logic [FLAT_W-1:0] cur_q;
   logic [FLAT_W-1:0] ref_q;
   logic              vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         ref_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            cur_q <= cur_pix;
            ref_q <= ref_pix;
         end
      end
   end

   logic [SAD_W-1:0] diffs [NUM_PIX];

   for (genvar i = 0; i < NUM_PIX; i++) begin : g_lane
      sad_absdiff #(.PIX_W(PIX_W), .OUT_W(SAD_W)) u_ad (
         .a_i  (cur_q[i*PIX_W +: PIX_W]),
         .b_i  (ref_q[i*PIX_W +: PIX_W]),
         .mag_o(diffs[i])
      );
   end

   logic [SAD_W-1:0] red_a;
   logic [SAD_W-1:0] red_b;
   logic [SAD_W-1:0] total;

   sad_csa_tree #(.N(NUM_PIX), .W(SAD_W)) u_tree (
      .ops_i  (diffs),
      .vec_a_o(red_a),
      .vec_b_o(red_b)
   );

   sad_cpa #(.W(SAD_W)) u_cpa (
      .a_i  (red_a),
      .b_i  (red_b),
      .sum_o(total)
   );

   if (OUT_REG) begin : g_oreg
      logic [SAD_W-1:0] sad_q;
      logic             ov_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sad_q <= '0;
            ov_q  <= 1'b0;
         end else begin
            ov_q <= vld_q;
            if (vld_q) sad_q <= total;
         end
      end
      assign sad_out   = sad_q;
      assign out_valid = ov_q;
   end else begin : g_comb
      assign sad_out   = total;
      assign out_valid = vld_q;
   end
endmodule

// File: rtl/sad4x4_csa_chk.sv
module sad4x4_csa_chk
   import sad_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int NUM_PIX = 16,
   parameter int SAD_W   = 12,
   parameter bit OUT_REG = 1'b0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic [NUM_PIX*PIX_W-1:0] cur_pix,
   input logic [NUM_PIX*PIX_W-1:0] ref_pix,
   input logic                     out_valid,
   input logic [SAD_W-1:0]         sad_out
);
   localparam int LAT     = 1 + int'(OUT_REG);
   localparam int SUM_MAX = max_sum(NUM_PIX, PIX_W);

   // R1: reset state
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (!out_valid && sad_out == '0)
            else $error("R1: outputs not cleared in reset");
      end
   end

   // R2: valid follows the sample strobe by the latency
   a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, LAT))
      else $error("R2: out_valid does not track in_valid");

   // R5: result never exceeds the largest possible sum
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      sad_out <= SAD_W'(SUM_MAX))
      else $error("R5: sad_out above maximum");

   // R6: identical blocks give zero
   a_r6_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && (cur_pix == ref_pix), LAT) |-> (sad_out == '0))
      else $error("R6: equal blocks gave nonzero sad");

   // R7: no sample, no change
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid, LAT) |-> $stable(sad_out))
      else $error("R7: sad_out changed without a sample");
endmodule

bind sad4x4_csa sad4x4_csa_chk #(
   .PIX_W  (PIX_W),
   .NUM_PIX(NUM_PIX),
   .SAD_W  (SAD_W),
   .OUT_REG(OUT_REG)
) u_chk (.*);

// File: tb/sad4x4_csa_test.sv
module sad4x4_csa_test;
   localparam int PW = 8;
   localparam int NP = 16;
   localparam int SW = 12;
   localparam int FW = NP * PW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [FW-1:0] cur_pix = '0;
   logic [FW-1:0] ref_pix = '0;
   logic          out_valid;
   logic [SW-1:0] sad_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sad4x4_csa uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .cur_pix  (cur_pix),
      .ref_pix  (ref_pix),
      .out_valid(out_valid),
      .sad_out  (sad_out)
   );

   function automatic int model_sad(input logic [FW-1:0] c, input logic [FW-1:0] r);
      int s;
      s = 0;
      for (int i = 0; i < NP; i++) begin
         int a;
         int b;
         a = int'(c[i*PW +: PW]);
         b = int'(r[i*PW +: PW]);
         s += (a > b) ? (a - b) : (b - a);
      end
      return s;
   endfunction

   function automatic logic [FW-1:0] rand_blk();
      logic [FW-1:0] v;
      for (int i = 0; i < NP; i++) v[i*PW +: PW] = 8'($urandom_range(0, 255));
      return v;
   endfunction

   function automatic logic [FW-1:0] fill_blk(input logic [7:0] p);
      logic [FW-1:0] v;
      for (int i = 0; i < NP; i++) v[i*PW +: PW] = p;
      return v;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one sample, check result one cycle later
   task automatic run_one(input string req, input logic [FW-1:0] c, input logic [FW-1:0] r);
      @(negedge clk);
      in_valid = 1'b1;
      cur_pix  = c;
      ref_pix  = r;
      @(posedge clk);
      #1;
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " sad"}, int'(sad_out), model_sad(c, r));
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 sad in reset", int'(sad_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 valid after release", int'(out_valid), 0);
      check("R1 sad after release", int'(sad_out), 0);
   endtask

   task automatic t_extremes();
      run_one("R5 max cur", fill_blk(8'hFF), fill_blk(8'h00));
      check("R5 value", int'(sad_out), 4080);
      run_one("R5 max ref", fill_blk(8'h00), fill_blk(8'hFF));
      check("R5 value swapped", int'(sad_out), 4080);
   endtask

   task automatic t_equal();
      logic [FW-1:0] b;
      b = rand_blk();
      run_one("R6 equal random", b, b);
      check("R6 zero", int'(sad_out), 0);
      run_one("R6 all zero", fill_blk(8'h00), fill_blk(8'h00));
      run_one("R6 all 255", fill_blk(8'hFF), fill_blk(8'hFF));
   endtask

   task automatic t_random();
      for (int k = 0; k < 24; k++) run_one("R3 random", rand_blk(), rand_blk());
      // single-lane patterns to expose position errors
      for (int i = 0; i < NP; i++) begin
         logic [FW-1:0] c;
         c = '0;
         c[i*PW +: PW] = 8'(i * 13 + 7);
         run_one("R3 single lane", c, '0);
      end
   endtask

   task automatic t_swap();
      for (int k = 0; k < 4; k++) begin
         logic [FW-1:0] a;
         logic [FW-1:0] b;
         int first;
         a = rand_blk();
         b = rand_blk();
         run_one("R4 forward", a, b);
         first = int'(sad_out);
         run_one("R4 reverse", b, a);
         check("R4 symmetric", int'(sad_out), first);
      end
   endtask

   task automatic t_hold();
      int kept;
      run_one("R7 setup", rand_blk(), rand_blk());
      kept = int'(sad_out);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         cur_pix  = rand_blk();
         ref_pix  = fill_blk(8'(k * 40));
         @(posedge clk);
         #1;
         check("R7 valid low", int'(out_valid), 0);
         check("R7 sad held", int'(sad_out), kept);
      end
   endtask

   task automatic t_b2b();
      logic [FW-1:0] c;
      logic [FW-1:0] r;
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         c = rand_blk();
         r = rand_blk();
         in_valid = 1'b1;
         cur_pix  = c;
         ref_pix  = r;
         @(posedge clk);
         #1;
         check("R8 b2b valid", int'(out_valid), 1);
         check("R8 b2b sad", int'(sad_out), model_sad(c, r));
         check("R2 latency", int'(out_valid), 1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R2 valid drops", int'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_extremes();
      t_equal();
      t_random();
      t_swap();
      t_hold();
      t_b2b();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule